// File: doc/BRIEF.md
# Display Controller Serial Register Slave

This block sits on the chip side of a small display controller and turns chip-select-framed SPI traffic into register-file operations. Every frame opens with a command byte. The top five bits of that byte carry a fixed signature, the next bit carries the device identifier, and the last two bits select the phase (index or data) and the direction (write or read). The block keeps an 8-bit index that points into a 16-bit register file. Data frames then write the indexed register, read it, or read a status word supplied by the core.

A host sets the index in one frame, raises chip select, and then moves the 16-bit value in a second frame. Read frames return one zero dummy byte before the value, high byte first. Register 0 always reads back a fixed driver code, so a host can confirm the part is present. The rest of the controller sees a one-cycle write strobe with address and data, and a combinational read port into the same storage. The serial inputs are oversampled by the system clock through a configurable synchronizer.

Top module: `dispctl_spi_regs`

## Requirements
- R1: The command byte is decoded only when bits 7..3 equal 01110 and bit 2 equals `DEV_ID`. In any other case the rest of the frame is ignored: MISO stays 0 until chip select rises, and neither the index nor any register changes.
- R2: Command byte with bit 1 = 0 and bit 0 = 0 (0x74 for `DEV_ID` = 1) is an index write. The second byte is ignored, and the third byte becomes the index.
- R3: Command byte with bit 1 = 1 and bit 0 = 0 (0x76) is a register write. Bytes two and three form the value, high byte first. It raises `core_wr_stb` for exactly one clock with the index and the value, and only while chip select is low.
- R4: Command byte with bit 1 = 1 and bit 0 = 1 (0x77) is a register read. MISO returns 0x00 and then the indexed register, MSB first. MISO changes on falling SCLK, and MOSI is sampled on rising SCLK.
- R5: Command byte with bit 1 = 0 and bit 0 = 1 (0x75) is a status read. MISO returns 0x00 and then `status_in`, captured when the command byte completes.
- R6: Index 0 reads back `DRIVER_CODE` (default 0x9221) on both read paths. A write to index 0 still strobes the core, but the value read back does not change.
- R7: A frame whose chip select rises before its third byte completes changes neither the index nor any register, and produces no strobe.
- R8: An index at or above `DEPTH` (64) drops writes without a strobe and reads as 0x0000.
- R9: Bytes after the third byte of a frame are ignored.
- R10: After reset MISO is 0, no strobe is active, the index is 0 and every register reads 0 apart from index 0.
- R11: `core_rd_data` returns the value stored at `core_rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_csn | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 when idle |
| status_in | input | 16 | Status word returned by status reads |
| core_wr_stb | output | 1 | One-cycle register write strobe |
| core_wr_addr | output | 8 | Index of the register being written |
| core_wr_data | output | 16 | Value being written |
| core_rd_addr | input | 8 | Core-side read index |
| core_rd_data | output | 16 | Core-side read value |

## Verification
The bench builds the block with `DEV_ID` = 1, `DEPTH` = 64, two synchronizer stages and the default driver code. The serial clock runs at one sixteenth of the system clock. With a depth of 64, a single index byte can land on the last implemented register (0x3F) and on the first missing one (0x40). The two-stage synchronizer keeps the MISO turnaround inside one SCLK half period. Because the ID bit is 1, clearing that bit in a command byte exercises the identifier mismatch, apart from the case where the signature bits are corrupted.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
   localparam int IDX_W  = 8;
   localparam int WORD_W = 16;
   localparam int BYTE_W = 8;
   localparam logic [4:0] CMD_SIGNATURE = 5'b01110;

   typedef enum logic [2:0] {
      FR_CMD,
      FR_HI,
      FR_LO,
      FR_DONE,
      FR_SKIP
   } frame_st_t;

   typedef struct packed {
      logic data_phase;   // 1: register data, 0: index / status
      logic rd;           // 1: read
   } cmd_t;
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] rst_val,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= rst_val;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= rst_val;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dsr_regfile.sv
module dsr_regfile
   import dsr_pkg::*;
#(
   parameter int             DEPTH       = 64,
   parameter logic [15:0]    DRIVER_CODE = 16'h9221
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   output logic              wr_accept,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [WORD_W-1:0] rd_data_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [WORD_W-1:0] rd_data_b
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [WORD_W-1:0] mem [DEPTH];

   function automatic logic in_range(input logic [IDX_W-1:0] idx);
      return int'(idx) < DEPTH;
   endfunction

   function automatic logic [WORD_W-1:0] lookup(input logic [IDX_W-1:0] idx);
      if (!in_range(idx))  return '0;
      else if (idx == '0)  return DRIVER_CODE;
      else                 return mem[idx[AW-1:0]];
   endfunction

   assign wr_accept = wr_req && in_range(wr_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_accept) begin
         mem[wr_idx[AW-1:0]] <= wr_data;
      end
   end

   assign rd_data_a = lookup(rd_idx_a);
   assign rd_data_b = lookup(rd_idx_b);
endmodule

// File: rtl/dsr_frame.sv
module dsr_frame
   import dsr_pkg::*;
#(
   parameter logic DEV_ID = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sclk_s,
   input  logic              mosi_s,
   input  logic [WORD_W-1:0] reg_rd_data,
   input  logic [WORD_W-1:0] status_in,
   output logic              miso,
   output logic [IDX_W-1:0]  idx_q,
   output logic              wr_req,
   output logic [WORD_W-1:0] wr_data
);
   localparam int TX_W = BYTE_W + WORD_W;

   frame_st_t         state;
   cmd_t              cmd;
   logic              sclk_d;
   logic [2:0]        bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] hi_byte;
   logic [TX_W-1:0]   tx;

   logic              rise, fall, byte_done, cmd_ok;
   logic [BYTE_W-1:0] byte_v;

   always_comb begin
      rise      = sclk_s && !sclk_d;
      fall      = !sclk_s && sclk_d;
      byte_v    = {shreg[BYTE_W-2:0], mosi_s};
      byte_done = rise && (bit_cnt == 3'd7);
      cmd_ok    = (byte_v[7:3] == CMD_SIGNATURE) && (byte_v[2] == DEV_ID);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= FR_CMD;
         cmd     <= '0;
         bit_cnt <= '0;
         shreg   <= '0;
         hi_byte <= '0;
         tx      <= '0;
         miso    <= 1'b0;
         idx_q   <= '0;
         wr_req  <= 1'b0;
         wr_data <= '0;
      end else if (cs_n_s) begin
         state   <= FR_CMD;
         bit_cnt <= '0;
         tx      <= '0;
         miso    <= 1'b0;
         wr_req  <= 1'b0;
      end else begin
         wr_req <= 1'b0;
         if (rise) begin
            shreg   <= byte_v;
            bit_cnt <= bit_cnt + 3'd1;
         end
         if (byte_done) begin
            unique case (state)
               FR_CMD: begin
                  if (cmd_ok) begin
                     cmd   <= '{data_phase: byte_v[1], rd: byte_v[0]};
                     state <= FR_HI;
                     if (byte_v[0])
                        tx <= {{BYTE_W{1'b0}}, byte_v[1] ? reg_rd_data : status_in};
                  end else begin
                     state <= FR_SKIP;
                  end
               end
               FR_HI: begin
                  hi_byte <= byte_v;
                  state   <= FR_LO;
               end
               FR_LO: begin
                  if (!cmd.rd) begin
                     if (cmd.data_phase) begin
                        wr_data <= {hi_byte, byte_v};
                        wr_req  <= 1'b1;
                     end else begin
                        idx_q <= byte_v;
                     end
                  end
                  state <= FR_DONE;
               end
               default: state <= state;
            endcase
         end
         if (fall) begin
            miso <= tx[TX_W-1];
            tx   <= {tx[TX_W-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/dispctl_spi_regs.sv
module dispctl_spi_regs
   import dsr_pkg::*;
#(
   parameter logic        DEV_ID      = 1'b1,
   parameter int          DEPTH       = 64,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] DRIVER_CODE = 16'h9221
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        spi_sclk,
   input  logic        spi_csn,
   input  logic        spi_mosi,
   output logic        spi_miso,
   input  logic [15:0] status_in,
   output logic        core_wr_stb,
   output logic [7:0]  core_wr_addr,
   output logic [15:0] core_wr_data,
   input  logic [7:0]  core_rd_addr,
   output logic [15:0] core_rd_data
);
   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("DEPTH must lie in 2..256");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 2..4");
   end

   logic [2:0]        pins_s;
   logic [IDX_W-1:0]  idx_q;
   logic              wr_req;
   logic              wr_accept;
   logic [WORD_W-1:0] wr_data;
   logic [WORD_W-1:0] idx_rd_data;

   dsr_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .rst_val (3'b010),
      .d       ({spi_sclk, spi_csn, spi_mosi}),
      .q       (pins_s)
   );

   dsr_frame #(.DEV_ID(DEV_ID)) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_s      (pins_s[1]),
      .sclk_s      (pins_s[2]),
      .mosi_s      (pins_s[0]),
      .reg_rd_data (idx_rd_data),
      .status_in   (status_in),
      .miso        (spi_miso),
      .idx_q       (idx_q),
      .wr_req      (wr_req),
      .wr_data     (wr_data)
   );

   dsr_regfile #(.DEPTH(DEPTH), .DRIVER_CODE(DRIVER_CODE)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (wr_req),
      .wr_idx    (idx_q),
      .wr_data   (wr_data),
      .wr_accept (wr_accept),
      .rd_idx_a  (idx_q),
      .rd_data_a (idx_rd_data),
      .rd_idx_b  (core_rd_addr),
      .rd_data_b (core_rd_data)
   );

   assign core_wr_stb  = wr_accept;
   assign core_wr_addr = idx_q;
   assign core_wr_data = wr_data;
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
   parameter int          DEPTH       = 64,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] DRIVER_CODE = 16'h9221
) (
   input logic        clk,
   input logic        rst_n,
   input logic        spi_csn,
   input logic        spi_miso,
   input logic        core_wr_stb,
   input logic [7:0]  core_wr_addr,
   input logic [7:0]  core_rd_addr,
   input logic [15:0] core_rd_data
);
   logic [3:0] cs_high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cs_high_cnt <= '0;
      else if (!spi_csn)               cs_high_cnt <= '0;
      else if (cs_high_cnt != 4'hF)    cs_high_cnt <= cs_high_cnt + 4'd1;
   end

   // R1 / R10: MISO is quiet once the deselect has crossed the synchronizer
   a_r1_miso_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cs_high_cnt) > SYNC_STAGES + 1) |-> !spi_miso);

   // R3: strobe lasts exactly one cycle
   a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr_stb |=> !core_wr_stb);

   // R3: strobes only inside a selected frame
   a_r3_strobe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr_stb |-> !spi_csn);

   // R8: no strobe for a missing register
   a_r8_strobe_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      core_wr_stb |-> (int'(core_wr_addr) < DEPTH));

   // R6: index 0 always yields the driver code on the core port
   a_r6_code_on_core_port: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rd_addr == 8'h00) |-> (core_rd_data == DRIVER_CODE));
endmodule

bind dispctl_spi_regs dsr_checker #(
   .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES), .DRIVER_CODE(DRIVER_CODE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .spi_csn      (spi_csn),
   .spi_miso     (spi_miso),
   .core_wr_stb  (core_wr_stb),
   .core_wr_addr (core_wr_addr),
   .core_rd_addr (core_rd_addr),
   .core_rd_data (core_rd_data)
);

// File: tb/dispctl_spi_regs_bench.sv
module dispctl_spi_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sclk = 1'b0;
   logic        spi_csn = 1'b1;
   logic        spi_mosi = 1'b0;
   logic        spi_miso;
   logic [15:0] status_in = 16'h0000;
   logic        core_wr_stb;
   logic [7:0]  core_wr_addr;
   logic [15:0] core_wr_data;
   logic [7:0]  core_rd_addr = 8'h05;
   logic [15:0] core_rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [23:0] exp_wr_q [$];
   logic [7:0]  txb [8];
   logic [7:0]  rxb [8];

   always #4 clk = ~clk;

   dispctl_spi_regs u_dispctl_spi_regs (
      .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .status_in(status_in),
      .core_wr_stb(core_wr_stb), .core_wr_addr(core_wr_addr),
      .core_wr_data(core_wr_data), .core_rd_addr(core_rd_addr),
      .core_rd_data(core_rd_data)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: every strobe must match the head of the expected-write queue (R3, R8)
   always @(negedge clk) begin
      if (rst_n && core_wr_stb) begin
         if (exp_wr_q.size() == 0) begin
            check(1'b0, "R3/R8 unexpected strobe", {8'h0, core_wr_addr, core_wr_data}, 32'h0);
         end else begin
            logic [23:0] e;
            e = exp_wr_q.pop_front();
            check({core_wr_addr, core_wr_data} == e, "R3 strobe addr/data",
                  {8'h0, core_wr_addr, core_wr_data}, {8'h0, e});
         end
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // nbytes: bytes shifted; cut: stop after this many bits (early release)
   task automatic spi_frame(input int nbytes, input int cut);
      int bits;
      bits = 0;
      spi_csn = 1'b0;
      wait_clk(8);
      for (int b = 0; b < nbytes; b++) begin
         rxb[b] = 8'h00;
         for (int i = 7; i >= 0; i--) begin
            if (bits < cut) begin
               spi_mosi = txb[b][i];
               wait_clk(8);
               spi_sclk = 1'b1;
               rxb[b][i] = spi_miso;
               wait_clk(8);
               spi_sclk = 1'b0;
               bits++;
            end
         end
      end
      wait_clk(8);
      spi_csn = 1'b1;
      wait_clk(16);
   endtask

   task automatic set_index(input logic [7:0] hi, input logic [7:0] idx);
      txb[0] = 8'h74; txb[1] = hi; txb[2] = idx;
      spi_frame(3, 24);
   endtask

   task automatic write_reg(input logic [7:0] idx, input logic [15:0] v, input bit expect_stb);
      if (expect_stb) exp_wr_q.push_back({idx, v});
      txb[0] = 8'h76; txb[1] = v[15:8]; txb[2] = v[7:0];
      spi_frame(3, 24);
   endtask

   task automatic read_frame(input logic [7:0] cmd, input logic [15:0] exp, input string req);
      txb[0] = cmd; txb[1] = 8'h5A; txb[2] = 8'hC3; txb[3] = 8'hFF;
      spi_frame(4, 32);
      check(rxb[0] == 8'h00, req, {24'h0, rxb[0]}, 32'h0);
      check({rxb[1], rxb[2], rxb[3]} == {8'h00, exp}, req,
            {8'h0, rxb[1], rxb[2], rxb[3]}, {16'h0, exp});
   endtask

   initial begin
      wait_clk(5);
      // R10: reset state
      check(spi_miso == 1'b0, "R10 miso after reset", {31'h0, spi_miso}, 32'h0);
      check(core_wr_stb == 1'b0, "R10 strobe after reset", {31'h0, core_wr_stb}, 32'h0);
      rst_n = 1'b1;
      wait_clk(5);
      check(core_rd_data == 16'h0000, "R10 register clear", {16'h0, core_rd_data}, 32'h0);
      read_frame(8'h77, 16'h9221, "R10/R6 index 0 after reset");

      // R6: driver code on both ports
      core_rd_addr = 8'h00; wait_clk(1);
      check(core_rd_data == 16'h9221, "R6 core port code", {16'h0, core_rd_data}, 32'h9221);

      // R2, R3, R4, R11: index then write then read
      set_index(8'h00, 8'h05);
      write_reg(8'h05, 16'hA5C3, 1'b1);
      read_frame(8'h77, 16'hA5C3, "R4 read back idx 5");
      core_rd_addr = 8'h05; wait_clk(1);
      check(core_rd_data == 16'hA5C3, "R11 core read idx 5", {16'h0, core_rd_data}, 32'hA5C3);

      // R2: upper index byte is ignored; last implemented register
      set_index(8'hE7, 8'h3F);
      write_reg(8'h3F, 16'h1234, 1'b1);
      read_frame(8'h77, 16'h1234, "R2 idx 0x3F with junk upper byte");

      // R8: out of range
      set_index(8'h00, 8'h40);
      write_reg(8'h40, 16'hFFFF, 1'b0);
      read_frame(8'h77, 16'h0000, "R8 read beyond depth");
      core_rd_addr = 8'h40; wait_clk(1);
      check(core_rd_data == 16'h0000, "R8 core read beyond depth", {16'h0, core_rd_data}, 32'h0);

      // R5: status read
      status_in = 16'hBEEF;
      read_frame(8'h75, 16'hBEEF, "R5 status read");
      status_in = 16'h0F0F;
      read_frame(8'h75, 16'h0F0F, "R5 status read second value");

      // R1: wrong ID bit and wrong signature are ignored
      set_index(8'h00, 8'h05);
      txb[0] = 8'h72; txb[1] = 8'h11; txb[2] = 8'h22;
      spi_frame(3, 24);
      txb[0] = 8'h73; txb[1] = 8'h00; txb[2] = 8'h00;
      spi_frame(3, 24);
      check({rxb[0], rxb[1], rxb[2]} == 24'h0, "R1 miso zero on wrong id",
            {8'h0, rxb[0], rxb[1], rxb[2]}, 32'h0);
      txb[0] = 8'hF4; txb[1] = 8'h00; txb[2] = 8'h3F;
      spi_frame(3, 24);
      txb[0] = 8'hF6; txb[1] = 8'h99; txb[2] = 8'h99;
      spi_frame(3, 24);
      read_frame(8'h77, 16'hA5C3, "R1 index and data untouched");

      // R7: early release of index and write frames
      txb[0] = 8'h74; txb[1] = 8'h00; txb[2] = 8'h3F;
      spi_frame(3, 20);
      txb[0] = 8'h76; txb[1] = 8'h00; txb[2] = 8'h01;
      spi_frame(3, 16);
      read_frame(8'h77, 16'hA5C3, "R7 aborted frames change nothing");

      // R9: trailing bytes ignored
      exp_wr_q.push_back({8'h05, 16'h6E21});
      txb[0] = 8'h76; txb[1] = 8'h6E; txb[2] = 8'h21; txb[3] = 8'hAB; txb[4] = 8'hCD;
      spi_frame(5, 40);
      read_frame(8'h77, 16'h6E21, "R9 extra bytes ignored");

      // R6: write to index 0 strobes but keeps the code
      set_index(8'h00, 8'h00);
      write_reg(8'h00, 16'h0001, 1'b1);
      read_frame(8'h77, 16'h9221, "R6 code after write");

      wait_clk(10);
      check(exp_wr_q.size() == 0, "R3 all expected strobes seen", exp_wr_q.size(), 32'h0);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule